// File: doc/BRIEF.md
# One-Hot Selected Parallel ALU

A combinational 16-bit arithmetic logic unit. Six function units work on the two operands side by side: a ripple-carry adder that also subtracts, a bitwise AND, a bitwise XOR, a left shifter, a right shifter and a pass-through of the second operand. A 3-bit operation code is decoded into one enable line per unit. Each result bit is formed by gating every unit's bit with its enable and ORing the gated bits together. Because the enables are one-hot or all zero, only one unit reaches the output.

Both shifters take their distance from the low bits of the second operand. A single decoder turns that binary distance into one-hot shift lines, and these drive an AND-OR shift matrix. The block holds no state. Carry and overflow are dropped, so arithmetic wraps modulo 2^16.

Top module: `onehot_alu`

## Requirements
- R1: With op_code 0, result equals (opnd_x + opnd_y) mod 2^16. The carry out of the top bit is lost.
- R2: With op_code 1, result equals (opnd_x - opnd_y) mod 2^16. This is formed by adding the bitwise inverse of opnd_y with a carry-in of 1.
- R3: With op_code 2, result equals opnd_x AND opnd_y, bit by bit.
- R4: With op_code 3, result equals opnd_x XOR opnd_y, bit by bit.
- R5: With op_code 4, result equals opnd_x shifted left by opnd_y[3:0] places. Zeros enter at bit 0.
- R6: With op_code 5, result equals opnd_x shifted right logically by opnd_y[3:0] places. Zeros enter at bit 15.
- R7: With op_code 6, result equals opnd_y, whatever opnd_x holds.
- R8: With op_code 7, no unit is enabled and result is 0 for any operands.
- R9: For op_code 4 and op_code 5, bits 15 down to 4 of opnd_y have no effect on result. Only opnd_y[3:0] sets the shift distance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 3 | Operation select: 0 add, 1 subtract, 2 AND, 3 XOR, 4 shift left, 5 shift right, 6 copy opnd_y, 7 none |
| opnd_x | input | 16 | First operand; the value that is shifted |
| opnd_y | input | 16 | Second operand; its low 4 bits give the shift distance |
| result | output | 16 | Output of the enabled unit, or 0 when no unit is enabled |

## Verification
The bench builds the block with its default width of 16. At that width the shift-distance field is 4 bits, so every one of the 16 shift distances can be driven, including 0 and the largest, 15. At that width the carry out of bit 15 is also easy to force, using operands such as 0xFFFF and 0x8000. The same width lets random shift operands set the upper bits of opnd_y, which shows that those bits are ignored.

// File: rtl/onehot_alu_pkg.sv
package onehot_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_XOR  = 3'd3,
    OP_SHL  = 3'd4,
    OP_SHR  = 3'd5,
    OP_PASS = 3'd6,
    OP_NONE = 3'd7
  } alu_op_e;

  localparam int OP_W    = 3;
  localparam int N_UNITS = 6;
  localparam int U_ARITH = 0;
  localparam int U_AND   = 1;
  localparam int U_XOR   = 2;
  localparam int U_SHL   = 3;
  localparam int U_SHR   = 4;
  localparam int U_PASS  = 5;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import onehot_alu_pkg::*;
(
  input  logic [OP_W-1:0]    op_code,
  output logic [N_UNITS-1:0] unit_en,
  output logic               sub_mode
);

  always_comb begin
    unit_en  = '0;
    sub_mode = 1'b0;
    case (op_code)
      OP_ADD:  unit_en[U_ARITH] = 1'b1;
      OP_SUB: begin
        unit_en[U_ARITH] = 1'b1;
        sub_mode         = 1'b1;
      end
      OP_AND:  unit_en[U_AND]  = 1'b1;
      OP_XOR:  unit_en[U_XOR]  = 1'b1;
      OP_SHL:  unit_en[U_SHL]  = 1'b1;
      OP_SHR:  unit_en[U_SHR]  = 1'b1;
      OP_PASS: unit_en[U_PASS] = 1'b1;
      default: unit_en = '0;
    endcase
  end

endmodule

// File: rtl/ripple_addsub.sv
module ripple_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] sum_out
);

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] b_eff;

  assign carry[0] = sub_mode;
  assign b_eff    = b_in ^ {WIDTH{sub_mode}};

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_fa
      assign sum_out[i]  = a_in[i] ^ b_eff[i] ^ carry[i];
      assign carry[i+1]  = (a_in[i] & b_eff[i]) | (a_in[i] & carry[i]) | (b_eff[i] & carry[i]);
    end
  endgenerate

  logic unused_cout;
  assign unused_cout = carry[WIDTH];

endmodule

// File: rtl/shift_matrix.sv
module shift_matrix #(
  parameter int WIDTH  = 16,
  parameter bit LEFT   = 1'b1
) (
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] dist_oh,
  output logic [WIDTH-1:0] dout
);

  genvar i, k;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      logic [WIDTH-1:0] terms;
      for (k = 0; k < WIDTH; k++) begin : g_dist
        if (LEFT && (i >= k)) begin : g_l
          assign terms[k] = dist_oh[k] & din[i-k];
        end else if (!LEFT && (i + k < WIDTH)) begin : g_r
          assign terms[k] = dist_oh[k] & din[i+k];
        end else begin : g_zero
          assign terms[k] = 1'b0;
        end
      end
      assign dout[i] = |terms;
    end
  endgenerate

endmodule

// File: rtl/onehot_combine.sv
module onehot_combine #(
  parameter int WIDTH   = 16,
  parameter int N_SRC   = 6
) (
  input  logic [N_SRC-1:0][WIDTH-1:0] src,
  input  logic [N_SRC-1:0]            en,
  output logic [WIDTH-1:0]            dout
);

  genvar b, u;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [N_SRC-1:0] gated;
      for (u = 0; u < N_SRC; u++) begin : g_src
        assign gated[u] = en[u] & src[u][b];
      end
      assign dout[b] = |gated;
    end
  endgenerate

endmodule

// File: rtl/onehot_alu.sv
module onehot_alu
  import onehot_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [2:0]       op_code,
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  output logic [WIDTH-1:0] result
);

  localparam int SHW = $clog2(WIDTH);

  logic [N_UNITS-1:0]            unit_en;
  logic                          sub_mode;
  logic [WIDTH-1:0]              shift_oh;
  logic [N_UNITS-1:0][WIDTH-1:0] unit_res;

  alu_op_decode u_dec (
    .op_code  (op_code),
    .unit_en  (unit_en),
    .sub_mode (sub_mode)
  );

  genvar k;
  generate
    for (k = 0; k < WIDTH; k++) begin : g_shdec
      assign shift_oh[k] = (opnd_y[SHW-1:0] == SHW'(k));
    end
  endgenerate

  ripple_addsub #(.WIDTH(WIDTH)) u_arith (
    .a_in     (opnd_x),
    .b_in     (opnd_y),
    .sub_mode (sub_mode),
    .sum_out  (unit_res[U_ARITH])
  );

  assign unit_res[U_AND]  = opnd_x & opnd_y;
  assign unit_res[U_XOR]  = opnd_x ^ opnd_y;
  assign unit_res[U_PASS] = opnd_y;

  shift_matrix #(.WIDTH(WIDTH), .LEFT(1'b1)) u_shl (
    .din     (opnd_x),
    .dist_oh (shift_oh),
    .dout    (unit_res[U_SHL])
  );

  shift_matrix #(.WIDTH(WIDTH), .LEFT(1'b0)) u_shr (
    .din     (opnd_x),
    .dist_oh (shift_oh),
    .dout    (unit_res[U_SHR])
  );

  onehot_combine #(.WIDTH(WIDTH), .N_SRC(N_UNITS)) u_mix (
    .src  (unit_res),
    .en   (unit_en),
    .dout (result)
  );

endmodule

// File: rtl/onehot_alu_chk.sv
module onehot_alu_chk
  import onehot_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic [2:0]         op_code,
  input logic [WIDTH-1:0]   opnd_x,
  input logic [WIDTH-1:0]   opnd_y,
  input logic [WIDTH-1:0]   result,
  input logic [N_UNITS-1:0] unit_en,
  input logic [WIDTH-1:0]   shift_oh
);

  localparam int SHW = $clog2(WIDTH);

  always_comb begin
    a_r8_enables_onehot0: assert ($onehot0(unit_en))
      else $error("R8 more than one unit enabled");
    a_r5_shift_onehot: assert ($countones(shift_oh) == 1)
      else $error("R5 shift select not one-hot");
    if (op_code == 3'd7) begin
      a_r8_idle_zero: assert (unit_en == '0 && result == '0)
        else $error("R8 idle code produced output");
    end
    if (op_code == 3'd0) begin
      a_r1_add_wrap: assert (result == WIDTH'(opnd_x + opnd_y))
        else $error("R1 add mismatch");
    end
    if (op_code == 3'd1) begin
      a_r2_sub_wrap: assert (result == WIDTH'(opnd_x - opnd_y))
        else $error("R2 sub mismatch");
    end
    if (op_code == 3'd2) begin
      a_r3_and: assert (result == (opnd_x & opnd_y))
        else $error("R3 and mismatch");
    end
    if (op_code == 3'd3) begin
      a_r4_xor: assert (result == (opnd_x ^ opnd_y))
        else $error("R4 xor mismatch");
    end
    if (op_code == 3'd4) begin
      a_r5_shl: assert (result == (opnd_x << opnd_y[SHW-1:0]))
        else $error("R5 shl mismatch");
    end
    if (op_code == 3'd5) begin
      a_r6_shr: assert (result == (opnd_x >> opnd_y[SHW-1:0]))
        else $error("R6 shr mismatch");
    end
    if (op_code == 3'd6) begin
      a_r7_copy: assert (result == opnd_y)
        else $error("R7 copy mismatch");
    end
  end

endmodule

bind onehot_alu onehot_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .op_code  (op_code),
  .opnd_x   (opnd_x),
  .opnd_y   (opnd_y),
  .result   (result),
  .unit_en  (unit_en),
  .shift_oh (shift_oh)
);

// File: tb/onehot_alu_tb.sv
`timescale 1ns/1ps
module onehot_alu_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_code = 3'd7;
  logic [15:0] opnd_x = '0;
  logic [15:0] opnd_y = '0;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  onehot_alu u_dut (
    .op_code (op_code),
    .opnd_x  (opnd_x),
    .opnd_y  (opnd_y),
    .result  (result)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] model(input logic [2:0] op, input logic [15:0] x, input logic [15:0] y);
    logic [15:0] r;
    int d;
    d = int'(y[3:0]);
    r = 16'h0;
    case (op)
      3'd0: r = 16'((32'(x) + 32'(y)) % 32'h10000);
      3'd1: r = 16'((32'(x) + 32'h10000 - 32'(y)) % 32'h10000);
      3'd2: r = x & y;
      3'd3: r = x ^ y;
      3'd4: for (int i = 0; i < 16; i++) if (i >= d) r[i] = x[i-d];
      3'd5: for (int i = 0; i < 16; i++) if (i + d < 16) r[i] = x[i+d];
      3'd6: r = y;
      default: r = 16'h0;
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_val(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s op=%0d x=%h y=%h actual=%h expected=%h", req, op_code, opnd_x, opnd_y, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [15:0] x, input logic [15:0] y, input string req);
    @(negedge clk);
    op_code = op;
    opnd_x  = x;
    opnd_y  = y;
    #5;
    check_val(req, result, model(op, x, y));
  endtask

  initial begin
    logic [15:0] base;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #5;
    check_val("R8", result, 16'h0000);

    apply(3'd0, 16'hFFFF, 16'h0001, "R1");
    apply(3'd0, 16'h8000, 16'h8000, "R1");
    apply(3'd0, 16'h1234, 16'h4321, "R1");
    apply(3'd1, 16'h0000, 16'h0001, "R2");
    apply(3'd1, 16'h8000, 16'h0001, "R2");
    apply(3'd1, 16'hFFFF, 16'hFFFF, "R2");
    apply(3'd2, 16'hFFFF, 16'h0F0F, "R3");
    apply(3'd3, 16'hFFFF, 16'h8000, "R4");
    apply(3'd4, 16'h8001, 16'h0000, "R5");
    apply(3'd4, 16'h0001, 16'h000F, "R5");
    apply(3'd4, 16'hFFFF, 16'h000F, "R5");
    apply(3'd5, 16'h8000, 16'h000F, "R6");
    apply(3'd5, 16'hFFFF, 16'h000F, "R6");
    apply(3'd5, 16'h8000, 16'h0000, "R6");
    apply(3'd6, 16'hFFFF, 16'h8000, "R7");
    apply(3'd6, 16'h0000, 16'hFFFF, "R7");
    apply(3'd7, 16'hFFFF, 16'hFFFF, "R8");
    apply(3'd7, 16'h8000, 16'h8000, "R8");

    // R9: upper bits of the shift operand must not change the distance
    for (int s = 0; s < 16; s++) begin
      base = 16'($urandom);
      apply(3'd4, base, 16'hFFF0 | 16'(s), "R9");
      apply(3'd5, base, 16'hA5A0 | 16'(s), "R9");
    end

    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      op = 3'($urandom % 8);
      apply(op, 16'($urandom), 16'($urandom), req_of(op));
    end

    #5;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule